// File: doc/BRIEF.md
# Power Management Alert Response Sequencer

This block is the host-side controller that services the power-management alert of a configurable device. It samples the active-low alert line on a fixed poll timer. When the line reads low on two consecutive polls, it asks an external SMBus byte engine for an alert-response-address read. The byte returned by that read names the responding device. The block then sends that device a voltage-setting write that carries a 16-bit target code. From the first poll that sees the alert, a hard deadline counter runs. If the voltage write has not completed when the deadline expires, the block raises a timeout.

Any acknowledge failure or missed deadline sends the block down an error path. It reads the device's status byte, latches that byte on an output and holds an error code until software clears it. After a successful voltage write it returns to polling, so it can serve later alerts. The electrical bus, the byte engine and the regulator lie outside this block.

The engine interface is a level request. `req_valid` stays high together with the kind, address, command and data fields until the engine pulses `rsp_done` for one cycle. The engine flags a failed acknowledge on `rsp_ackfail` in that same cycle. When `req_valid` falls without a `rsp_done`, the engine must drop the transaction.

Top module: `pm_alert_seq`

## Requirements
- R1: The alert line is sampled once every POLL_TICKS cycles. With the alert held low, the first request appears no sooner than POLL_TICKS+1 cycles and no later than 2*POLL_TICKS+4 cycles after the alert falls.
- R2: No request is issued unless the synchronised alert reads low on two consecutive polls. A low pulse that spans a single poll, or a high poll between two low ones, issues nothing.
- R3: The first request of each service is a receive-byte to the alert-response address 0x0C. Its kind code is 0, and its command and data fields are zero.
- R4: A good alert-response read is followed by a write-word of kind 1 with command 0x21. Its address is bits 7:1 of the returned byte and its data word is `vout_code`.
- R5: The deadline starts at the first poll that sees the alert. If the voltage write has not completed DL_TICKS cycles after that poll, `req_valid` drops for at least one cycle. The status read follows, and `err_code` becomes 2.
- R6: An acknowledge failure on the alert-response read or on the voltage write leads straight to a status read. That read has kind 2 and command 0x78 and targets the last captured device address. Afterwards `err_code` becomes 1.
- R7: When the status read completes, `status_byte` takes the returned byte. If the status read itself fails to acknowledge, `status_byte` becomes 0xFF.
- R8: While `err_code` is non-zero, the code holds and no request is issued, even with the alert low. A one-cycle `err_clr` clears the code and resumes polling.
- R9: After a successful voltage write, `vout_ok` pulses high for exactly one cycle with `req_valid` low. The block then goes back to polling and serves a later alert again.
- R10: During and right after reset, `req_valid`, `vout_ok`, `err_code` and `status_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alert_n | input | 1 | Asynchronous active-low alert from the device |
| vout_code | input | 16 | Target voltage code sent with the voltage write |
| err_clr | input | 1 | Clears a latched error and resumes polling |
| req_valid | output | 1 | Transaction request to the byte engine, held until done |
| req_kind | output | 2 | 0 receive-byte, 1 write-word, 2 read-byte |
| req_addr | output | 7 | Target device address |
| req_cmd | output | 8 | Command code |
| req_wdata | output | 16 | Data word for write-word |
| rsp_done | input | 1 | One-cycle completion pulse from the engine |
| rsp_ackfail | input | 1 | Acknowledge failure, valid with rsp_done |
| rsp_rdata | input | 8 | Byte returned by a read, valid with rsp_done |
| status_byte | output | 8 | Status byte latched on the error path |
| err_code | output | 2 | 0 none, 1 acknowledge failure, 2 deadline missed |
| vout_ok | output | 1 | One-cycle pulse when a voltage write completes in time |

## Verification
The assertions assume the engine pulses `rsp_done` only while `req_valid` is high, and for only one cycle per request. They also assume the engine never answers a request that was withdrawn. The bench's engine model keeps to this. It replies after a chosen delay with a single-cycle pulse. In the deadline case it stays silent and waits for the withdrawal before it serves the status read. The alert stimulus changes only on falling clock edges. It is released once the device has been addressed, so that each service ends cleanly before the next pattern.

// File: rtl/pm_alert_pkg.sv
package pm_alert_pkg;

    typedef enum logic [2:0] {
        ST_POLL  = 3'd0,
        ST_ARA   = 3'd1,
        ST_VOUT  = 3'd2,
        ST_ABORT = 3'd3,
        ST_STAT  = 3'd4,
        ST_ERR   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_RECV   = 2'd0,
        KIND_WRWORD = 2'd1,
        KIND_RDBYTE = 2'd2
    } txn_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NAK     = 2'd1,
        ERR_TIMEOUT = 2'd2
    } err_code_e;

    localparam logic [6:0] ALERT_RESP_ADDR = 7'h0C;
    localparam logic [7:0] CMD_SET_VOUT    = 8'h21;
    localparam logic [7:0] CMD_READ_STATUS = 8'h78;

endpackage

// File: rtl/pm_alert_sync.sv
module pm_alert_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pm_poll_timer.sv
module pm_poll_timer #(
    parameter int POLL_TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic poll_o
);
    localparam int CW = (POLL_TICKS > 2) ? $clog2(POLL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign poll_o = (cnt_q == LAST);

    // R1: the interval counter never leaves its range, so polls stay evenly spaced
    p_poll_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pm_deadline.sv
module pm_deadline #(
    parameter int DL_TICKS = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic expired
);
    localparam int CW = $clog2(DL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DL_TICKS);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } dl_regs_t;

    dl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.run = 1'b1;
            r_d.cnt = '0;
        end else if (stop) begin
            r_d.run = 1'b0;
        end else if (r_q.run && r_q.cnt != LIMIT) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expired = r_q.run && (r_q.cnt == LIMIT);

    // R5: the count saturates at the deadline and never wraps back into range
    p_dl_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LIMIT);
endmodule

// File: rtl/pm_alert_seq.sv
module pm_alert_seq
    import pm_alert_pkg::*;
#(
    parameter int POLL_TICKS = 1_000_000,
    parameter int DL_TICKS   = 20_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alert_n,
    input  logic [15:0] vout_code,
    input  logic        err_clr,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic [6:0]  req_addr,
    output logic [7:0]  req_cmd,
    output logic [15:0] req_wdata,
    input  logic        rsp_done,
    input  logic        rsp_ackfail,
    input  logic [7:0]  rsp_rdata,
    output logic [7:0]  status_byte,
    output logic [1:0]  err_code,
    output logic        vout_ok
);
    typedef struct packed {
        seq_state_e state;
        logic       low_seen;
        logic [6:0] tgt;
        logic [7:0] status;
        err_code_e  err;
        err_code_e  pend;
        logic       vout_ok;
    } seq_regs_t;

    localparam seq_regs_t RESET_REGS = '{
        state: ST_POLL, low_seen: 1'b0, tgt: '0, status: '0,
        err: ERR_NONE, pend: ERR_NONE, vout_ok: 1'b0};

    logic alert_s;
    logic alert_low;
    logic poll;
    logic dl_start, dl_stop, dl_expired;

    seq_regs_t r_d, r_q;

    pm_alert_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(alert_n), .dout(alert_s));

    assign alert_low = ~alert_s;

    pm_poll_timer #(.POLL_TICKS(POLL_TICKS)) u_poll (
        .clk(clk), .rst_n(rst_n), .poll_o(poll));

    pm_deadline #(.DL_TICKS(DL_TICKS)) u_dl (
        .clk(clk), .rst_n(rst_n), .start(dl_start), .stop(dl_stop),
        .expired(dl_expired));

    // Deadline control: armed by the first low poll, halted by a high poll,
    // by the voltage write finishing, or by leaving the service states.
    always_comb begin
        dl_start = (r_q.state == ST_POLL) && poll && alert_low && !r_q.low_seen;
        dl_stop  = ((r_q.state == ST_POLL) && poll && !alert_low)
                 || ((r_q.state == ST_VOUT) && rsp_done)
                 || !(r_q.state inside {ST_POLL, ST_ARA, ST_VOUT});
    end

    always_comb begin
        r_d         = r_q;
        r_d.vout_ok = 1'b0;
        case (r_q.state)
            ST_POLL: begin
                if (poll) begin
                    if (!alert_low) begin
                        r_d.low_seen = 1'b0;
                    end else if (r_q.low_seen) begin
                        r_d.low_seen = 1'b0;
                        r_d.state    = ST_ARA;
                    end else begin
                        r_d.low_seen = 1'b1;
                    end
                end
            end
            ST_ARA: begin
                if (dl_expired) begin
                    r_d.pend  = ERR_TIMEOUT;
                    r_d.state = ST_ABORT;
                end else if (rsp_done) begin
                    if (rsp_ackfail) begin
                        r_d.pend  = ERR_NAK;
                        r_d.state = ST_STAT;
                    end else begin
                        r_d.tgt   = rsp_rdata[7:1];
                        r_d.state = ST_VOUT;
                    end
                end
            end
            ST_VOUT: begin
                if (dl_expired) begin
                    r_d.pend  = ERR_TIMEOUT;
                    r_d.state = ST_ABORT;
                end else if (rsp_done) begin
                    if (rsp_ackfail) begin
                        r_d.pend  = ERR_NAK;
                        r_d.state = ST_STAT;
                    end else begin
                        r_d.vout_ok = 1'b1;
                        r_d.state   = ST_POLL;
                    end
                end
            end
            ST_ABORT: begin
                r_d.state = ST_STAT;
            end
            ST_STAT: begin
                if (rsp_done) begin
                    r_d.status = rsp_ackfail ? 8'hFF : rsp_rdata;
                    r_d.err    = r_q.pend;
                    r_d.state  = ST_ERR;
                end
            end
            ST_ERR: begin
                if (err_clr) begin
                    r_d.err      = ERR_NONE;
                    r_d.pend     = ERR_NONE;
                    r_d.low_seen = 1'b0;
                    r_d.state    = ST_POLL;
                end
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    // Request decode from the registered state.
    always_comb begin
        req_valid = 1'b0;
        req_kind  = KIND_RECV;
        req_addr  = '0;
        req_cmd   = '0;
        req_wdata = '0;
        case (r_q.state)
            ST_ARA: begin
                req_valid = 1'b1;
                req_kind  = KIND_RECV;
                req_addr  = ALERT_RESP_ADDR;
            end
            ST_VOUT: begin
                req_valid = 1'b1;
                req_kind  = KIND_WRWORD;
                req_addr  = r_q.tgt;
                req_cmd   = CMD_SET_VOUT;
                req_wdata = vout_code;
            end
            ST_STAT: begin
                req_valid = 1'b1;
                req_kind  = KIND_RDBYTE;
                req_addr  = r_q.tgt;
                req_cmd   = CMD_READ_STATUS;
            end
            default: ;
        endcase
    end

    assign status_byte = r_q.status;
    assign err_code    = r_q.err;
    assign vout_ok     = r_q.vout_ok;

    // R3: every new service opens with the alert-response read
    p_ara_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_kind != KIND_RDBYTE)
            |-> (req_kind == KIND_RECV && req_addr == ALERT_RESP_ADDR));

    // R2: the alert-response read starts only on a poll that saw the line low
    p_gated_by_alert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_kind == KIND_RECV)
            |-> ($past(poll) && $past(alert_low)));

    // R5: a voltage write is never reported good once the deadline has passed
    p_vout_in_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vout_ok |-> !$past(dl_expired));

    // R8: the error code holds until cleared
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0 && !err_clr) |=> (err_code == $past(err_code)));

    // R8: no bus traffic while an error is latched
    p_quiet_in_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> !req_valid);

    // R4: a pending request keeps its kind and target until answered or withdrawn
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_done && !dl_expired)
            |=> (req_valid && $stable(req_kind) && $stable(req_addr)));
endmodule

// File: tb/pm_alert_seq_tb.sv
module pm_alert_seq_tb;
    localparam int P = 8;
    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alert_n = 1'b1;
    logic [15:0] vout_code = '0;
    logic        err_clr = 1'b0;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [6:0]  req_addr;
    logic [7:0]  req_cmd;
    logic [15:0] req_wdata;
    logic        rsp_done = 1'b0;
    logic        rsp_ackfail = 1'b0;
    logic [7:0]  rsp_rdata = '0;
    logic [7:0]  status_byte;
    logic [1:0]  err_code;
    logic        vout_ok;

    int nchk = 0;
    int nfail = 0;
    bit req_seen = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pm_alert_seq #(.POLL_TICKS(P), .DL_TICKS(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .alert_n(alert_n), .vout_code(vout_code),
        .err_clr(err_clr), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_ackfail(rsp_ackfail), .rsp_rdata(rsp_rdata),
        .status_byte(status_byte), .err_code(err_code), .vout_ok(vout_ok));

    always @(negedge clk) if (req_valid) req_seen = 1'b1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input int limit, output int lat);
        lat = 0;
        while (!req_valid && lat < limit) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic respond(input int dly, input bit nak, input logic [7:0] rd);
        tick(dly);
        rsp_done = 1'b1; rsp_ackfail = nak; rsp_rdata = rd;
        @(negedge clk);
        rsp_done = 1'b0; rsp_ackfail = 1'b0; rsp_rdata = '0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err_code == 2'd0, "R8", "err_code after clear", err_code, 0);
        tick(3 * P);
    endtask

    initial begin
        int lat;
        int t0;
        tick(4);
        check(!req_valid && !vout_ok && err_code == 0 && status_byte == 0,
              "R10", "outputs in reset", {req_valid, vout_ok, err_code, status_byte}, 0);
        rst_n = 1'b1;
        tick(1);
        check(!req_valid && err_code == 0, "R10", "outputs after reset",
              {req_valid, err_code}, 0);
        tick(2 * P);

        // R2: every low pulse shorter than one poll interval is ignored
        req_seen = 1'b0;
        for (int len = 1; len < P; len++) begin
            alert_n = 1'b0; tick(len);
            alert_n = 1'b1; tick(3 * P);
        end
        check(!req_seen, "R2", "request after short pulse", req_seen, 0);
        // R2: low / high / low across polls still does nothing
        req_seen = 1'b0;
        alert_n = 1'b0; tick(P - 1);
        alert_n = 1'b1; tick(P);
        alert_n = 1'b0; tick(P - 1);
        alert_n = 1'b1; tick(3 * P);
        check(!req_seen, "R2", "request after split lows", req_seen, 0);

        // R1 R3 R4 R9: sweep of services with various codes, targets, delays
        for (int i = 0; i < 6; i++) begin
            logic [6:0]  dev;
            logic [15:0] code;
            dev  = 7'(7'h11 + 13 * i);
            code = 16'(16'h0357 * (i + 1) + 16'h1000 * i);
            vout_code = code;
            alert_n = 1'b0;
            wait_req(4 * P, lat);
            check(lat >= P + 1 && lat <= 2 * P + 4, "R1", "first request latency", lat, P + 1);
            check(req_valid && req_kind == 2'd0 && req_addr == 7'h0C && req_cmd == 0,
                  "R3", "alert response read", {req_kind, req_addr}, {2'd0, 7'h0C});
            alert_n = 1'b1;
            respond(1 + i, 1'b0, {dev, 1'b0});
            check(req_valid && req_kind == 2'd1 && req_addr == dev && req_cmd == 8'h21,
                  "R4", "voltage write header", {req_kind, req_addr, req_cmd},
                  {2'd1, dev, 8'h21});
            check(req_wdata == code, "R4", "voltage write data", req_wdata, code);
            respond(i, 1'b0, 8'h00);
            check(vout_ok && !req_valid, "R9", "vout_ok pulse", {vout_ok, req_valid}, 2'b10);
            tick(1);
            check(!vout_ok && err_code == 0, "R9", "vout_ok single cycle", vout_ok, 0);
            tick(3 * P);
        end

        // R6 R7: acknowledge failure on the alert-response read
        alert_n = 1'b0;
        wait_req(4 * P, lat);
        respond(2, 1'b1, 8'h00);
        check(req_valid && req_kind == 2'd2 && req_cmd == 8'h78 && req_addr == 7'(7'h11 + 65),
              "R6", "status read after ara nak", {req_kind, req_cmd, req_addr},
              {2'd2, 8'h78, 7'(7'h11 + 65)});
        respond(1, 1'b0, 8'hA5);
        check(err_code == 2'd1, "R6", "err_code nak", err_code, 1);
        check(status_byte == 8'hA5, "R7", "status byte", status_byte, 8'hA5);

        // R8: held error with alert still low
        req_seen = 1'b0;
        tick(5 * P);
        check(!req_seen && err_code == 2'd1, "R8", "quiet while error latched",
              {req_seen, err_code}, 1);
        alert_n = 1'b1;
        clear_err();

        // R6 R7: nak on voltage write, then status read also fails
        alert_n = 1'b0;
        wait_req(4 * P, lat);
        alert_n = 1'b1;
        respond(0, 1'b0, {7'h2A, 1'b1});
        respond(3, 1'b1, 8'h00);
        check(req_valid && req_kind == 2'd2 && req_addr == 7'h2A, "R6",
              "status read after write nak", {req_kind, req_addr}, {2'd2, 7'h2A});
        respond(0, 1'b1, 8'h33);
        check(status_byte == 8'hFF, "R7", "status on failed read", status_byte, 8'hFF);
        check(err_code == 2'd1, "R6", "err_code write nak", err_code, 1);
        clear_err();

        // R5: voltage write never answered
        alert_n = 1'b0;
        t0 = 0;
        wait_req(4 * P, lat);
        t0 = lat;
        alert_n = 1'b1;
        respond(1, 1'b0, {7'h35, 1'b0});
        t0 += 2;
        while (req_valid && t0 < D + 4 * P) begin @(negedge clk); t0++; end
        check(!req_valid, "R5", "request withdrawn at deadline", req_valid, 0);
        wait_req(8, lat);
        t0 += lat;
        check(t0 > D && t0 <= D + P + 8, "R5", "status read time", t0, D);
        check(req_valid && req_kind == 2'd2 && req_addr == 7'h35, "R5",
              "status read after timeout", {req_kind, req_addr}, {2'd2, 7'h35});
        respond(2, 1'b0, 8'h5A);
        check(err_code == 2'd2, "R5", "err_code timeout", err_code, 2);
        check(status_byte == 8'h5A, "R7", "status after timeout", status_byte, 8'h5A);
        clear_err();

        // R9: service works again after recovery
        vout_code = 16'hBEEF;
        alert_n = 1'b0;
        wait_req(4 * P, lat);
        check(req_valid && req_kind == 2'd0, "R9", "ara after recovery", req_kind, 0);
        alert_n = 1'b1;
        respond(0, 1'b0, {7'h40, 1'b0});
        check(req_wdata == 16'hBEEF, "R4", "data after recovery", req_wdata, 16'hBEEF);
        respond(0, 1'b0, 8'h00);
        check(vout_ok, "R9", "vout_ok after recovery", vout_ok, 1);

        finished = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected finish", cyc);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule